// File: doc/BRIEF.md
# Pipelined Range-Lookup Bin Classifier

This block maps each incoming sample to the number of the bin whose value range contains it. Bins are laid out along the sample axis by a set of writable upper bounds. The lower edge of each bin is the upper bound of the bin before it, and the lowest bin starts at zero. A typical use is to turn a skewed stream of measured values into a more even stream of bin indices, by giving busy regions of the axis narrower bins.

The classifier is a chain of identical stages, one per bin. A sample moves forward by one stage on every clock. The stage whose window holds the sample overwrites the payload with its own index and raises a found flag. Once that flag is up, no later stage may change the sample. A new sample can enter on every clock, so output throughput equals input throughput. Latency is fixed at one cycle per bin. A sample that leaves the last stage without a match is marked as a miss and keeps its raw value.

Top module: `bin_classifier`

## Requirements
- R1: During reset and after it, `out_valid` is low until a sample has passed through. After reset, upper bound k holds (k+1)*2^DATA_W/N - 1, so every bin has the same width (4096 wide for N=16, DATA_W=16).
- R2: A sample x is assigned to bin k when bound[k-1] < x <= bound[k], with bin 0 covering 0..bound[0]. On a hit, `out_miss` is 0 and `out_value` holds k, zero-extended.
- R3: The first stage that matches owns the sample. A later stage whose window also holds x leaves both the value and the found flag unchanged, even when the bounds are not increasing.
- R4: A sample that no stage matches leaves with `out_miss` = 1 and `out_value` equal to the raw sample.
- R5: A sample presented with `in_valid` high before clock edge t appears on the outputs after edge t+N-1. That is exactly N registered stages.
- R6: Samples may enter on every clock. Every input cycle with `in_valid` low produces exactly one output cycle with `out_valid` low, in the same order.
- R7: When `wr_en` is high at an edge, bound `wr_idx` takes `wr_data` at that edge and all other bounds keep their values. A sample presented in the following cycle or later uses the new value. Equal neighbouring bounds give an empty bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | DATA_W | Value to classify |
| wr_en | input | 1 | Write strobe for one upper bound |
| wr_idx | input | $clog2(N) | Bin whose upper bound is written |
| wr_data | input | DATA_W | New upper bound |
| out_valid | output | 1 | Classified sample present |
| out_value | output | DATA_W | Bin index on a hit, raw sample on a miss |
| out_miss | output | 1 | No bin matched the sample |

## Verification
The in-stage assertions do not assume that the bounds increase. They relate each stage's registered slot to that stage's inputs and its two bounds in the previous cycle, so they also hold with overlapping or empty windows. The bank assertions take it as given that `wr_idx` names an existing bin. The stimulus writes bounds only while the chain is empty, or one cycle before the first sample that should see the change. That keeps the bench's reference model, which reads one fixed set of bounds per sample, valid. Random bounds are built as increasing sequences, and a few directed sets break that order on purpose to exercise the first-match rule.

// File: rtl/bin_pkg.sv
package bin_pkg;

    // Upper bound of bin k when n bins split a w-bit axis evenly.
    function automatic logic [63:0] even_bound(input int unsigned k,
                                               input int unsigned n,
                                               input int unsigned w);
        logic [63:0] span;
        logic [63:0] top;
        span = 64'd1 << w;
        top  = span * (64'(k) + 64'd1);
        return (top / 64'(n)) - 64'd1;
    endfunction

endpackage

// File: rtl/bin_bound_bank.sv
module bin_bound_bank #(
    parameter int N      = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [N-1:0][DATA_W-1:0]    bounds
);
    import bin_pkg::*;

    logic [N-1:0][DATA_W-1:0] bound_d, bound_q;

    always_comb begin
        bound_d = bound_q;
        if (wr_en && (32'(wr_idx) < N)) begin
            bound_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                bound_q[k] <= DATA_W'(even_bound(unsigned'(k), unsigned'(N), unsigned'(DATA_W)));
            end
        end else begin
            bound_q <= bound_d;
        end
    end

    assign bounds = bound_q;

    // R7
    wr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) < N)) |=> bound_q[$past(wr_idx)] == $past(wr_data));

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bound_q));

endmodule

// File: rtl/bin_stage.sv
module bin_stage #(
    parameter int DATA_W   = 16,
    parameter int STAGE_ID = 0,
    parameter int HAS_LO   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic              in_found,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] lo_bound,
    input  logic [DATA_W-1:0] hi_bound,
    output logic              out_v,
    output logic              out_found,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              v;
        logic              found;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  above_lo;
    logic  below_hi;
    logic  hit;

    always_comb begin
        above_lo     = (HAS_LO == 0) || (in_data > lo_bound);
        below_hi     = (in_data <= hi_bound);
        hit          = in_v && !in_found && above_lo && below_hi;
        slot_d.v     = in_v;
        slot_d.found = in_found || hit;
        slot_d.data  = hit ? DATA_W'(STAGE_ID) : in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_v     = slot_q.v;
    assign out_found = slot_q.found;
    assign out_data  = slot_q.data;

    // R3
    keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && in_found) |=> (out_found && out_data == $past(in_data)));

    // R2
    claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && !in_found && ((HAS_LO == 0) || in_data > lo_bound) && in_data <= hi_bound)
        |=> (out_found && out_data == DATA_W'(STAGE_ID)));

    // R4
    pass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && !in_found && !(((HAS_LO == 0) || in_data > lo_bound) && in_data <= hi_bound))
        |=> (!out_found && out_data == $past(in_data)));

endmodule

// File: rtl/bin_classifier.sv
module bin_classifier #(
    parameter int N      = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_miss
);
    logic [N-1:0][DATA_W-1:0] bounds;
    logic [N:0]               v_chain;
    logic [N:0]               found_chain;
    logic [N:0][DATA_W-1:0]   data_chain;

    bin_bound_bank #(.N(N), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bounds  (bounds)
    );

    assign v_chain[0]     = in_valid;
    assign found_chain[0] = 1'b0;
    assign data_chain[0]  = in_sample;

    for (genvar k = 0; k < N; k++) begin : g_stage
        if (k == 0) begin : g_first
            bin_stage #(.DATA_W(DATA_W), .STAGE_ID(k), .HAS_LO(0)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_v      (v_chain[k]),
                .in_found  (found_chain[k]),
                .in_data   (data_chain[k]),
                .lo_bound  ({DATA_W{1'b0}}),
                .hi_bound  (bounds[k]),
                .out_v     (v_chain[k+1]),
                .out_found (found_chain[k+1]),
                .out_data  (data_chain[k+1])
            );
        end else begin : g_rest
            bin_stage #(.DATA_W(DATA_W), .STAGE_ID(k), .HAS_LO(1)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_v      (v_chain[k]),
                .in_found  (found_chain[k]),
                .in_data   (data_chain[k]),
                .lo_bound  (bounds[k-1]),
                .hi_bound  (bounds[k]),
                .out_v     (v_chain[k+1]),
                .out_found (found_chain[k+1]),
                .out_data  (data_chain[k+1])
            );
        end
    end

    assign out_valid = v_chain[N];
    assign out_value = data_chain[N];
    assign out_miss  = v_chain[N] && !found_chain[N];

    // R2
    hit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_miss) |-> (out_value < DATA_W'(N)));

endmodule

// File: tb/tb_bin_classifier.sv
module tb_bin_classifier;
    localparam int N  = 16;
    localparam int W  = 16;
    localparam int IW = $clog2(N);
    localparam int MAXC = 4096;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  in_sample;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [W-1:0]  wr_data;
    logic          out_valid;
    logic [W-1:0]  out_value;
    logic          out_miss;

    bin_classifier #(.N(N), .DATA_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .out_valid (out_valid),
        .out_value (out_value),
        .out_miss  (out_miss)
    );

    always #10 clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    int    bb [N];
    bit    rec_v    [MAXC];
    int    rec_val  [MAXC];
    bit    rec_miss [MAXC];
    string rec_tag  [MAXC];

    function automatic void ref_model(input int x, output int val, output bit miss);
        val  = x;
        miss = 1'b1;
        for (int k = 0; k < N; k++) begin
            int lo;
            lo = (k == 0) ? -1 : bb[k-1];
            if (miss && x > lo && x <= bb[k]) begin
                val  = k;
                miss = 1'b0;
            end
        end
    endfunction

    task automatic check_out();
        bit    ev;
        int    idx;
        ev  = 1'b0;
        idx = cyc - N;
        if (idx >= 0) ev = rec_v[idx];
        n_chk++;
        if (out_valid !== ev) begin
            n_fail++;
            $display("FAIL R5 cycle %0d: out_valid actual=%0b expected=%0b", cyc, out_valid, ev);
        end else if (ev) begin
            if (out_miss !== rec_miss[idx] || int'(out_value) != rec_val[idx]) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual value=%0d miss=%0b expected value=%0d miss=%0b",
                         rec_tag[idx], cyc, out_value, out_miss, rec_val[idx], rec_miss[idx]);
            end
        end
    endtask

    task automatic drive(input bit v, input int x, input bit we, input int wi, input int wd,
                         input string tag);
        int  val;
        bit  miss;
        @(negedge clk);
        check_out();
        in_valid  = v;
        in_sample = W'(x);
        wr_en     = we;
        wr_idx    = IW'(wi);
        wr_data   = W'(wd);
        if (we) bb[wi] = wd;
        rec_v[cyc] = v;
        if (v) begin
            ref_model(x, val, miss);
            rec_val[cyc]  = val;
            rec_miss[cyc] = miss;
            rec_tag[cyc]  = tag;
        end
        cyc++;
    endtask

    task automatic sample(input int x, input string tag);
        drive(1'b1, x, 1'b0, 0, 0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0, 0, 0, "R6");
    endtask

    task automatic write_bound(input int k, input int val);
        drive(1'b0, 0, 1'b1, k, val, "R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_ret;
        int prev;
        seed_ret = $urandom(32'd20240607);
        rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        for (int k = 0; k < N; k++) bb[k] = ((k + 1) * 65536) / N - 1;

        // R1: idle outputs during reset
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 reset: out_valid actual=%0b expected=0", out_valid);
            end
        end
        rst_n = 1'b1;

        // R1: reset bounds split the axis evenly
        sample(0, "R1");
        sample(4095, "R1");
        sample(4096, "R1");
        sample(32767, "R1");
        sample(65535, "R1");
        // R2: random samples with bubbles
        for (int i = 0; i < 150; i++) begin
            if ($urandom_range(3, 0) == 0) idle(1);
            else sample(int'($urandom_range(65535, 0)), "R2");
        end
        idle(N + 2);

        // R7: new increasing bounds, last bound well below the top
        prev = -1;
        for (int k = 0; k < N; k++) begin
            prev = prev + 1 + int'($urandom_range(3500, 0));
            write_bound(k, prev);
        end
        sample(bb[0], "R7");
        sample(bb[0] + 1, "R7");
        sample(bb[7], "R2");
        sample(bb[7] + 1, "R2");
        sample(bb[N-1], "R2");
        // R4: above the last bound
        sample(bb[N-1] + 1, "R4");
        sample(65535, "R4");
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(4, 0) == 0) idle(1);
            else sample(int'($urandom_range(65535, 0)), "R2");
        end
        idle(N + 2);

        // R3: overlapping windows, the earlier stage must keep the sample
        write_bound(0, 1000);
        write_bound(1, 500);
        write_bound(2, 2000);
        sample(700, "R3");
        sample(501, "R3");
        sample(1000, "R3");
        sample(1500, "R2");
        sample(1001, "R2");
        idle(N + 2);

        // R6: back-to-back stream, no bubbles
        for (int i = 0; i < 200; i++) sample(int'($urandom_range(65535, 0)), "R6");
        idle(N + 2);

        // R7: empty bin from equal neighbours, written one cycle before use
        write_bound(3, 3000);
        write_bound(4, 4000);
        write_bound(5, 4000);
        sample(4000, "R7");
        sample(4001, "R7");
        sample(3001, "R7");
        idle(N + 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule